// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking a radix page table held in memory. The caller gives the byte address of the root directory, the index width of that root directory, and the tree size (the number of low effective-address bits that take part in translation). The walker then reads one 8-byte entry per level over a simple request/response memory port. After each read it either descends to the next directory or stops on a leaf.

The width of each level's index slice is not fixed. The first level uses the root size from the caller. Every later level uses the size stored in the non-leaf entry just fetched. Each slice is taken from the top of the effective-address bits that have not yet been consumed. When the walk reaches a leaf, the bits that are left over become the page offset.

When the walk ends, a one-cycle done pulse appears, together with either a fault flag or a translated address. A translated address comes with the reference, change, attribute and access-authority fields of the leaf. Entries use MSB-0 numbering: entry bit i is vector bit 63-i.

Top module: `radix_walker`

## Requirements
- R1: At start, if any effective-address bit at or above `treeSize` is set (`treeSize` < 64), the walk faults and issues no memory request.
- R2: The first request address is `rootBase + 8*idx`. Here `idx` is the `rootSize`-bit slice just below bit `treeSize` of the effective address.
- R3: A fetched entry with bit 0 (valid) set and bit 1 (leaf) clear makes the walker descend. It takes the next base from entry bits 4:55, shifted left by 8, and the next index width from entry bits 59:63. The next slice is taken from the top of the remaining bits, and the next address is base + 8*slice.
- R4: A fetched entry whose valid bit is clear ends the walk with a fault. No further request is issued.
- R5: A level whose index width is below 5 or above the number of remaining bits faults before its request. A width that exactly uses up the remaining bits is legal.
- R6: On a valid leaf, `realAddr` = (entry bits 7:51 << 12) OR (the effective-address bits that remain unconsumed).
- R7: On a valid leaf, `refBit` = entry bit 55, `chgBit` = entry bit 56, `attr` = entry bits 58:59 (00 normal, 01 strongly ordered, 10 non-idempotent I/O, 11 tolerant I/O), and `accAuth` = entry bits 60:63.
- R8: At most 5 entries (MAX_LEVELS) are fetched per walk. A non-leaf entry at the last allowed level faults.
- R9: `startReady` is high only while idle, and `startValid` has no effect while a walk is in progress. `memReq` is a one-cycle pulse, with at most one request outstanding.
- R10: After reset the walker is idle with all outputs zero. `done` is a one-cycle pulse, and on a fault all result fields read zero. Results hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a walk (taken when startReady) |
| startReady | output | 1 | Walker idle |
| effAddr | input | 64 | Effective address to translate |
| rootBase | input | 64 | Byte address of root directory |
| rootSize | input | 5 | Index width of root directory |
| treeSize | input | 7 | Number of translated low address bits |
| memReq | output | 1 | Entry read request pulse |
| memAddr | output | 64 | Entry byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Fetched entry |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk ended in a fault |
| realAddr | output | 64 | Translated real address |
| refBit | output | 1 | Leaf reference bit |
| chgBit | output | 1 | Leaf change bit |
| attr | output | 2 | Leaf storage attribute |
| accAuth | output | 4 | Leaf encoded access authority |

## Verification
The hardest cases to reach from the ports are the ones where entry contents drive the walk into a corner: the level cap, an index width that exactly uses up the remaining bits, and a width that overruns them. Each of these needs a consistent chain of directories at the exact addresses the slicing produces. The bench does not use a fixed table. For each effective address and each chosen list of widths, it computes the path arithmetically and writes entries only at those addresses. A memory model then answers requests from a sparse store and returns zero (an invalid entry) everywhere else, so any mis-sliced address surfaces as a fault. Sweeps over tree sizes, depths 1 to 5 and address patterns cover the main path. Targeted overwrites of single entries produce the fault cases.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  localparam int ENTRY_W = 64;
  localparam int VA_W    = 64;

  // Control-to-datapath strobes, at most one asserted per cycle.
  typedef struct packed {
    logic load;        // capture start inputs, clear results
    logic issue;       // latch request address, consume index bits
    logic descend;     // take next base and width from fetched entry
    logic finishLeaf;  // capture leaf translation
    logic finishFault; // capture fault outcome
  } walkStrobes_t;

  typedef enum logic [1:0] {
    ATT_NORMAL   = 2'b00,
    ATT_ORDERED  = 2'b01,
    ATT_NONIDEM  = 2'b10,
    ATT_TOLERANT = 2'b11
  } memAttr_e;

  // Mask of the n lowest bits, n in 0..64.
  function automatic logic [VA_W-1:0] lowMask(input logic [6:0] n);
    if (n >= 7'd64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/rpw_ctrl.sv
module rpw_ctrl
  import rpw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         rangeBad,
  input  logic         widthBad,
  input  logic         capHit,
  input  logic         rspValid,
  input  logic         entryValid,
  input  logic         entryLeaf,
  output walkStrobes_t strb,
  output logic         startReady,
  output logic         memReq,
  output logic         done
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT
  } walkState_e;

  walkState_e state, stateNext;
  logic       doneQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.load = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (rangeBad || capHit || widthBad) begin
          strb.finishFault = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strb.issue = 1'b1;
          stateNext  = ST_REQ;
        end
      end
      ST_REQ: begin
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (rspValid) begin
          if (!entryValid) begin
            strb.finishFault = 1'b1;
            stateNext        = ST_IDLE;
          end else if (entryLeaf) begin
            strb.finishLeaf = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            strb.descend = 1'b1;
            stateNext    = ST_CHECK;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= strb.finishLeaf | strb.finishFault;
    end
  end

  assign startReady = (state == ST_IDLE);
  assign memReq     = (state == ST_REQ);
  assign done       = doneQ;

endmodule

// File: rtl/rpw_datapath.sv
module rpw_datapath
  import rpw_pkg::*;
#(
  parameter int MAX_LEVELS   = 5,
  parameter int MIN_DIR_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobes_t         strb,
  input  logic [VA_W-1:0]      effAddr,
  input  logic [VA_W-1:0]      rootBase,
  input  logic [4:0]           rootSize,
  input  logic [6:0]           treeSize,
  input  logic [ENTRY_W-1:0]   memRspData,
  output logic                 rangeBad,
  output logic                 widthBad,
  output logic                 capHit,
  output logic [VA_W-1:0]      memAddr,
  output logic                 fault,
  output logic [VA_W-1:0]      realAddr,
  output logic                 refBit,
  output logic                 chgBit,
  output logic [1:0]           attr,
  output logic [3:0]           accAuth
);

  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  logic [VA_W-1:0]  eaQ;
  logic [VA_W-1:0]  baseQ;
  logic [4:0]       widthQ;
  logic [6:0]       remainQ;
  logic [6:0]       treeQ;
  logic [LVL_W-1:0] levelQ;
  logic [VA_W-1:0]  memAddrQ;

  logic             faultQ;
  logic [VA_W-1:0]  realQ;
  logic             refQ;
  logic             chgQ;
  memAttr_e         attrQ;
  logic [3:0]       authQ;

  logic [6:0]       widthExt;
  logic [6:0]       sliceShift;
  logic [VA_W-1:0]  slice;
  logic [VA_W-1:0]  nextAddr;
  logic [VA_W-1:0]  nextBase;
  logic [VA_W-1:0]  pageBase;
  logic             unusedRsp;

  // Entry bits (MSB-0): 0 valid and 1 leaf are decoded in control,
  // bit 57 of a leaf is reserved here.
  assign unusedRsp = ^{memRspData[63:60], memRspData[6]};

  assign widthExt   = {2'b00, widthQ};
  assign sliceShift = remainQ - widthExt;

  assign widthBad = (widthQ < 5'(MIN_DIR_BITS)) || (widthExt > remainQ);
  assign capHit   = (levelQ == LVL_W'(MAX_LEVELS));
  assign rangeBad = (treeQ < 7'd64) && ((eaQ >> treeQ) != '0);

  assign slice    = (eaQ >> sliceShift) & lowMask(widthExt);
  assign nextAddr = baseQ + (slice << 3);

  // Non-leaf: next base at entry bits 4:55, stored shifted right by 8.
  assign nextBase = {4'b0000, memRspData[59:8], 8'h00};
  // Leaf: real page number at entry bits 7:51.
  assign pageBase = {7'b0000000, memRspData[56:12], 12'h000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ      <= '0;
      baseQ    <= '0;
      widthQ   <= '0;
      remainQ  <= '0;
      treeQ    <= '0;
      levelQ   <= '0;
      memAddrQ <= '0;
    end else if (strb.load) begin
      eaQ     <= effAddr;
      baseQ   <= rootBase;
      widthQ  <= rootSize;
      remainQ <= treeSize;
      treeQ   <= treeSize;
      levelQ  <= '0;
    end else if (strb.issue) begin
      memAddrQ <= nextAddr;
      remainQ  <= sliceShift;
      levelQ   <= levelQ + 1'b1;
    end else if (strb.descend) begin
      baseQ  <= nextBase;
      widthQ <= memRspData[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.load || strb.finishFault) begin
      faultQ <= !rstN || strb.load ? 1'b0 : 1'b1;
      realQ  <= '0;
      refQ   <= 1'b0;
      chgQ   <= 1'b0;
      attrQ  <= ATT_NORMAL;
      authQ  <= '0;
    end else if (strb.finishLeaf) begin
      faultQ <= 1'b0;
      realQ  <= pageBase | (eaQ & lowMask(remainQ));
      refQ   <= memRspData[8];
      chgQ   <= memRspData[7];
      attrQ  <= memAttr_e'(memRspData[5:4]);
      authQ  <= memRspData[3:0];
    end
  end

  assign memAddr  = memAddrQ;
  assign fault    = faultQ;
  assign realAddr = realQ;
  assign refBit   = refQ;
  assign chgBit   = chgQ;
  assign attr     = attrQ;
  assign accAuth  = authQ;

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rpw_pkg::*;
#(
  parameter int MAX_LEVELS   = 5,
  parameter int MIN_DIR_BITS = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  output logic        startReady,
  input  logic [63:0] effAddr,
  input  logic [63:0] rootBase,
  input  logic [4:0]  rootSize,
  input  logic [6:0]  treeSize,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        done,
  output logic        fault,
  output logic [63:0] realAddr,
  output logic        refBit,
  output logic        chgBit,
  output logic [1:0]  attr,
  output logic [3:0]  accAuth
);

  walkStrobes_t strb;
  logic         rangeBad;
  logic         widthBad;
  logic         capHit;

  rpw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .rangeBad   (rangeBad),
    .widthBad   (widthBad),
    .capHit     (capHit),
    .rspValid   (memRspValid),
    .entryValid (memRspData[63]),
    .entryLeaf  (memRspData[62]),
    .strb       (strb),
    .startReady (startReady),
    .memReq     (memReq),
    .done       (done)
  );

  rpw_datapath #(
    .MAX_LEVELS   (MAX_LEVELS),
    .MIN_DIR_BITS (MIN_DIR_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .effAddr    (effAddr),
    .rootBase   (rootBase),
    .rootSize   (rootSize),
    .treeSize   (treeSize),
    .memRspData (memRspData),
    .rangeBad   (rangeBad),
    .widthBad   (widthBad),
    .capHit     (capHit),
    .memAddr    (memAddr),
    .fault      (fault),
    .realAddr   (realAddr),
    .refBit     (refBit),
    .chgBit     (chgBit),
    .attr       (attr),
    .accAuth    (accAuth)
  );

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int MAX_LEVELS = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        startValid,
  input logic        startReady,
  input logic        memReq,
  input logic        done,
  input logic        fault,
  input logic [63:0] realAddr,
  input logic        refBit,
  input logic        chgBit,
  input logic [1:0]  attr,
  input logic [3:0]  accAuth
);

  localparam int CNT_W = $clog2(MAX_LEVELS + 2) + 1;

  logic [CNT_W-1:0] reqCount;

  always_ff @(posedge clk) begin
    if (!rstN) reqCount <= '0;
    else if (startValid && startReady) reqCount <= '0;
    else if (memReq) reqCount <= reqCount + 1'b1;
  end

  // R9: request is a single-cycle pulse, one outstanding
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R9: no memory traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> !memReq);

  // R8: fetch count per walk never exceeds the level cap
  a_r8_level_cap: assert property (@(posedge clk) disable iff (!rstN)
    reqCount <= CNT_W'(MAX_LEVELS));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a fault reports zeroed result fields
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (realAddr == '0 && !refBit && !chgBit &&
                         attr == 2'b00 && accAuth == 4'h0));

endmodule

bind radix_walker radix_walker_chk #(.MAX_LEVELS(MAX_LEVELS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .startReady (startReady),
  .memReq     (memReq),
  .done       (done),
  .fault      (fault),
  .realAddr   (realAddr),
  .refBit     (refBit),
  .chgBit     (chgBit),
  .attr       (attr),
  .accAuth    (accAuth)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [63:0] effAddr = '0;
  logic [63:0] rootBase = '0;
  logic [4:0]  rootSize = '0;
  logic [6:0]  treeSize = '0;
  logic        memReq;
  logic [63:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done;
  logic        fault;
  logic [63:0] realAddr;
  logic        refBit;
  logic        chgBit;
  logic [1:0]  attr;
  logic [3:0]  accAuth;

  always #4 clk = ~clk;   // 125 MHz

  radix_walker u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .effAddr(effAddr), .rootBase(rootBase), .rootSize(rootSize), .treeSize(treeSize),
    .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .fault(fault), .realAddr(realAddr), .refBit(refBit), .chgBit(chgBit),
    .attr(attr), .accAuth(accAuth)
  );

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;
  logic finished = 1'b0;

  logic [63:0] mem [logic [63:0]];

  // sparse memory responder: answers one cycle after the request cycle
  int          reqSeen = 0;
  logic [63:0] firstAddr = '0;
  logic        pend = 1'b0;
  logic [63:0] pendData = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = pendData;
        pend        = 1'b0;
      end else begin
        memRspValid = 1'b0;
        memRspData  = '0;
      end
      if (memReq) begin
        if (reqSeen == 0) firstAddr = memAddr;
        reqSeen++;
        pend     = 1'b1;
        pendData = mem.exists(memAddr) ? mem[memAddr] : 64'h0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        nChk++; nFail++;
        $display("FAIL watchdog: run did not end (act=%0d cycles, exp<150000)", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
        $finish;
      end
    end
  end

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] maskN(input int n);
    if (n >= 64) return '1;
    if (n <= 0) return '0;
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] mkNonLeaf(input logic [63:0] nb, input int nls);
    logic [63:0] e = '0;
    e[63]   = 1'b1;
    e[59:8] = nb[59:8];
    e[4:0]  = nls[4:0];
    return e;
  endfunction

  function automatic logic [63:0] mkLeaf(input logic [44:0] rpn, input logic r, input logic c,
                                         input logic [1:0] at, input logic [3:0] au);
    logic [63:0] e = '0;
    e[63] = 1'b1; e[62] = 1'b1;
    e[56:12] = rpn; e[8] = r; e[7] = c; e[5:4] = at; e[3:0] = au;
    return e;
  endfunction

  int widths[8];

  // Lays entries along the path the slicing rules select; returns leftover bits.
  task automatic buildPath(input logic [63:0] ea, input logic [63:0] root, input int tsz,
                           input int nLev, input logic [63:0] leaf,
                           output int rem, output logic [63:0] lastAddr, output logic [63:0] firstA);
    logic [63:0] base = root;
    rem = tsz;
    for (int lv = 0; lv < nLev; lv++) begin
      int w = widths[lv];
      logic [63:0] idx = (ea >> (rem - w)) & maskN(w);
      logic [63:0] a = base + (idx << 3);
      if (lv == 0) firstA = a;
      rem -= w;
      lastAddr = a;
      if (lv == nLev - 1) mem[a] = leaf;
      else begin
        logic [63:0] nb = 64'h0000_0400_0000_0000 + 64'(lv + 1) * 64'h0010_0000;
        mem[a] = mkNonLeaf(nb, widths[lv + 1]);
        base = nb;
      end
    end
  endtask

  task automatic runWalk(input logic [63:0] ea, input logic [63:0] root, input int rsz,
                         input int tsz, input bit interfere);
    int t = 0;
    @(negedge clk);
    reqSeen = 0;
    effAddr = ea; rootBase = root; rootSize = rsz[4:0]; treeSize = tsz[6:0];
    startValid = 1'b1;
    @(negedge clk);
    if (interfere) begin
      checkEq("R9 ready low while busy", {63'b0, startReady}, 64'd0);
      effAddr = ~ea; rootBase = root + 64'h1000;
      @(negedge clk);
      startValid = 1'b0;
    end else startValid = 1'b0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R9 walk timeout: act=no done exp=done");
    end
  endtask

  task automatic expectLeaf(input string tag, input logic [63:0] expReal, input int expReqs,
                            input logic r, input logic c, input logic [1:0] at, input logic [3:0] au);
    checkEq({tag, " fault"}, {63'b0, fault}, 64'd0);
    checkEq({tag, " realAddr"}, realAddr, expReal);
    checkEq({tag, " reqs"}, 64'(reqSeen), 64'(expReqs));
    checkEq({tag, " fields"}, {56'b0, refBit, chgBit, attr, accAuth}, {56'b0, r, c, at, au});
  endtask

  task automatic expectFault(input string tag, input int expReqs);
    checkEq({tag, " fault"}, {63'b0, fault}, 64'd1);
    checkEq({tag, " reqs"}, 64'(reqSeen), 64'(expReqs));
    checkEq({tag, " zero realAddr"}, realAddr, 64'd0);
  endtask

  initial begin
    int rem;
    logic [63:0] lastA, firstA, ea, root, leaf;
    logic [44:0] rpn;

    repeat (3) @(negedge clk);
    // R10 reset state
    checkEq("R10 reset ready", {63'b0, startReady}, 64'd1);
    checkEq("R10 reset memReq", {63'b0, memReq}, 64'd0);
    checkEq("R10 reset done", {63'b0, done}, 64'd0);
    checkEq("R10 reset result", {realAddr[63:1], fault}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R6: depth and address sweep, two tree sizes
    widths[0] = 13; widths[1] = 9; widths[2] = 9; widths[3] = 9; widths[4] = 5;
    for (int ts = 0; ts < 2; ts++) begin
      int tsz = (ts == 0) ? 52 : 48;
      for (int nl = 1; nl <= 5; nl++) begin
        for (int k = 0; k < 6; k++) begin
          mem.delete();
          ea   = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 3 + nl)) & maskN(tsz);
          root = 64'h0000_0100_0000_0000 + 64'(k) * 64'h0100_0000;
          rpn  = 45'(64'h1_2345_6789 + 64'(k * 77 + nl));
          leaf = mkLeaf(rpn, 1'b1, 1'b0, 2'b01, 4'hA);
          buildPath(ea, root, tsz, nl, leaf, rem, lastA, firstA);
          runWalk(ea, root, widths[0], tsz, 1'b0);
          checkEq("R2 first request address", firstAddr, firstA);
          expectLeaf("R3 R6 sweep", ({19'b0, rpn} << 12) | (ea & maskN(rem)), nl,
                     1'b1, 1'b0, 2'b01, 4'hA);
        end
      end
    end

    // R7: leaf field sweep
    widths[0] = 10; widths[1] = 10;
    for (int i = 0; i < 16; i++) begin
      mem.delete();
      ea   = 64'h0000_0ABC_DEF1_2345 ^ 64'(i << 20);
      rpn  = 45'(i * 4099 + 5);
      leaf = mkLeaf(rpn, i[0], i[1], i[3:2], 4'(15 - i));
      buildPath(ea, 64'h8000, 52, 2, leaf, rem, lastA, firstA);
      runWalk(ea, 64'h8000, 10, 52, 1'b0);
      expectLeaf("R7 fields", ({19'b0, rpn} << 12) | (ea & maskN(rem)), 2,
                 i[0], i[1], i[3:2], 4'(15 - i));
    end

    // R1: address bits above tree size
    mem.delete();
    runWalk(64'h0010_0000_0000_0000, 64'h8000, 13, 52, 1'b0);
    expectFault("R1 bit at tree size", 0);
    runWalk(64'h1000_0000_0000_1234, 64'h8000, 13, 52, 1'b0);
    expectFault("R1 high bit", 0);

    // R4: invalid entries
    mem.delete();
    runWalk(64'h0000_0000_1234_5678, 64'h8000, 13, 52, 1'b0);
    expectFault("R4 invalid root entry", 1);
    widths[0] = 13; widths[1] = 9; widths[2] = 9;
    ea = 64'h000F_1234_5678_9ABC;
    leaf = mkLeaf(45'h77, 1'b1, 1'b1, 2'b11, 4'h3);
    buildPath(ea, 64'h8000, 52, 3, leaf, rem, lastA, firstA);
    mem[lastA] = leaf & ~(64'd1 << 63);
    runWalk(ea, 64'h8000, 13, 52, 1'b0);
    expectFault("R4 invalid third entry", 3);

    // R5: width bounds
    mem.delete();
    runWalk(ea, 64'h8000, 4, 52, 1'b0);
    expectFault("R5 root width below 5", 0);
    runWalk(64'h1234, 64'h8000, 20, 16, 1'b0);
    expectFault("R5 root width over tree", 0);
    mem.delete();
    buildPath(ea, 64'h8000, 52, 1, 64'h0, rem, lastA, firstA);
    mem[lastA] = mkNonLeaf(64'h0000_0400_0010_0000, 4);
    runWalk(ea, 64'h8000, 13, 52, 1'b0);
    expectFault("R5 next width below 5", 1);
    mem.delete();
    buildPath(64'h0_F0F0, 64'h8000, 20, 1, 64'h0, rem, lastA, firstA);
    mem[lastA] = mkNonLeaf(64'h0000_0400_0010_0000, 8);
    runWalk(64'h0_F0F0, 64'h8000, 13, 20, 1'b0);
    expectFault("R5 next width overruns", 1);
    mem.delete();
    widths[0] = 12; widths[1] = 12;
    leaf = mkLeaf(45'h1ABCD, 1'b0, 1'b1, 2'b10, 4'h5);
    buildPath(64'h00AB_CDEF, 64'h8000, 24, 2, leaf, rem, lastA, firstA);
    runWalk(64'h00AB_CDEF, 64'h8000, 12, 24, 1'b0);
    expectLeaf("R5 exact fit", {19'b0, 45'h1ABCD} << 12, 2, 1'b0, 1'b1, 2'b10, 4'h5);

    // R8: level cap
    mem.delete();
    for (int i = 0; i < 8; i++) widths[i] = 5;
    ea = 64'h000A_BCDE_F012_3456;
    buildPath(ea, 64'h8000, 52, 6, mkLeaf(45'h5, 1'b0, 1'b0, 2'b00, 4'h0), rem, lastA, firstA);
    runWalk(ea, 64'h8000, 5, 52, 1'b0);
    expectFault("R8 sixth level", 5);

    // R9: start ignored while busy
    mem.delete();
    widths[0] = 13; widths[1] = 9;
    ea = 64'h0003_3333_4444_5555;
    rpn = 45'h0BEEF;
    buildPath(ea, 64'h8000, 52, 2, mkLeaf(rpn, 1'b1, 1'b1, 2'b00, 4'h9), rem, lastA, firstA);
    runWalk(ea, 64'h8000, 13, 52, 1'b1);
    expectLeaf("R9 start while busy ignored", ({19'b0, rpn} << 12) | (ea & maskN(rem)), 2,
               1'b1, 1'b1, 2'b00, 4'h9);

    // R10: done is a pulse and results hold
    @(negedge clk);
    checkEq("R10 done pulse", {63'b0, done}, 64'd0);
    checkEq("R10 result holds", realAddr, ({19'b0, rpn} << 12) | (ea & maskN(rem)));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule